// File: doc/BRIEF.md
# Quadrature Position Counter with Index Reset

This block turns the two phase signals of an incremental shaft encoder into a signed position count. Each transition on either phase moves a 32-bit counter by one, so one full electrical cycle gives four counts. The direction of travel comes from which phase leads. If both phases change in the same clock, the transition cannot be trusted. The block does not count it and raises a sticky phase-error flag instead.

The encoder's once-per-turn index pulse can zero the counter. A two-bit mode input selects one of three behaviours: zero on every index event, zero only on the first index event since reset or the last clear, or never zero (free-running). A sticky marker flag records that the first index event has been seen. The clear input drops both flags and re-arms the first-index logic.

A rising index edge goes into a pending register that does not depend on phase activity. That event then takes effect on the next valid count, or three clocks later if no count arrives. An index edge close to a phase edge is therefore never lost. All inputs must already be synchronised to the clock.

Top module: `quad_pos_counter`

## Requirements
- R1: A valid forward transition adds one to the position and sets dir to 1. The phase order is {qa,qb} = 00, 10, 11, 01, 00, so A leads B.
- R2: A valid transition in the opposite order subtracts one from the position and sets dir to 0.
- R3: If qa and qb both change in the same clock, the position and dir do not change, and phase_err goes to 1. phase_err stays at 1 until mark_clr is asserted.
- R4: The position is 32 bits. It wraps from 0xFFFFFFFF to 0 when counting up and from 0 to 0xFFFFFFFF when counting down.
- R5: With rst_mode = 2'b00, every index event sets the position to 0.
- R6: With rst_mode = 2'b10, only the first index event after reset or after a clear sets the position to 0. Later events leave the position unchanged.
- R7: With rst_mode = 2'b01 or 2'b11, index events never change the position.
- R8: mark_flag goes to 1 on the first index event in any mode and stays at 1.
- R9: mark_clr clears mark_flag and phase_err and re-arms first-index detection. If a set and a clear happen in the same clock, the clear wins.
- R10: A rising edge on qi is held as pending. The index event happens at the next valid count, and that count is replaced by the zeroing. With no count, the event happens on the third clock after the edge is registered. An index edge one clock before, in the same clock as, or two clocks after a phase edge always produces an event.
- R11: Synchronous reset sets position to 0, dir to 1 and both flags to 0. The input levels present during reset become the baseline, so they produce no count and no index edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qa | input | 1 | Phase A, synchronised |
| qb | input | 1 | Phase B, synchronised |
| qi | input | 1 | Index, synchronised |
| rst_mode | input | 2 | Index reset mode: 00 every event, 10 first event only, 01/11 none |
| mark_clr | input | 1 | Clears the flags and re-arms first-index detection |
| position | output | 32 | Position count |
| dir | output | 1 | Last valid direction, 1 = forward |
| mark_flag | output | 1 | Sticky first-index marker |
| phase_err | output | 1 | Sticky illegal-transition flag |

## Verification
A change on qa or qb shows up on position, dir and phase_err after the first rising edge that samples it. The bench drives inputs on the falling edge and checks them half a clock after that edge. An index edge alone zeroes the position on the fourth rising edge after qi goes high: one edge to register the edge, then three edges of waiting. The bench checks the position on the third edge (still unchanged) and on the fourth (zeroed). When a count follows the index edge, the zeroing lands on the edge of that count. The tests for one clock before, the same clock and two clocks after a phase edge each check the exact cycle.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        RM_EVERY  = 2'b00,
        RM_FREE_A = 2'b01,
        RM_FIRST  = 2'b10,
        RM_FREE_B = 2'b11
    } rst_mode_e;

    typedef struct packed {
        logic step;
        logic up;
        logic err;
    } qstep_t;

    // Gray phase index of a sample: 00->0, 10->1, 11->2, 01->3
    function automatic logic [1:0] phase_of(input logic [1:0] ab);
        case (ab)
            2'b00:   phase_of = 2'd0;
            2'b10:   phase_of = 2'd1;
            2'b11:   phase_of = 2'd2;
            default: phase_of = 2'd3;
        endcase
    endfunction

    function automatic qstep_t decode(input logic [1:0] prev_ab, input logic [1:0] cur_ab);
        logic [1:0] diff;
        qstep_t     r;
        diff = phase_of(cur_ab) - phase_of(prev_ab);
        r.step = (diff == 2'd1) || (diff == 2'd3);
        r.up   = (diff == 2'd1);
        r.err  = (diff == 2'd2);
        return r;
    endfunction

endpackage

// File: rtl/qdec_phase.sv
module qdec_phase
    import qdec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   qa,
    input  logic   qb,
    output qstep_t st
);
    logic [1:0] prev_ab;

    always_ff @(posedge clk) begin
        prev_ab <= {qa, qb};
    end

    always_comb begin
        if (rst) st = '0;
        else     st = decode(prev_ab, {qa, qb});
    end
endmodule

// File: rtl/qdec_index.sv
module qdec_index #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic qi,
    input  logic step,
    output logic idx_evt
);
    localparam int AGE_W = $clog2(HOLD_CYC + 1);

    logic             qi_q;
    logic             pend;
    logic [AGE_W-1:0] age;
    logic             rise;

    assign rise    = qi & ~qi_q;
    assign idx_evt = pend && (step || (age == AGE_W'(HOLD_CYC - 1)));

    always_ff @(posedge clk) begin
        qi_q <= qi;
        if (rst) begin
            pend <= 1'b0;
            age  <= '0;
        end else if (rise) begin
            pend <= 1'b1;
            age  <= '0;
        end else if (idx_evt) begin
            pend <= 1'b0;
            age  <= '0;
        end else if (pend) begin
            age  <= age + AGE_W'(1);
        end
    end
endmodule

// File: rtl/qdec_pos.sv
module qdec_pos
    import qdec_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  qstep_t           st,
    input  logic             idx_evt,
    input  rst_mode_e        mode,
    input  logic             clr,
    output logic [POS_W-1:0] position,
    output logic             dir,
    output logic             mark_flag,
    output logic             phase_err
);
    logic do_zero;

    always_comb begin
        case (mode)
            RM_EVERY: do_zero = idx_evt;
            RM_FIRST: do_zero = idx_evt && !mark_flag;
            default:  do_zero = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            position  <= '0;
            dir       <= 1'b1;
            mark_flag <= 1'b0;
            phase_err <= 1'b0;
        end else begin
            if (do_zero)
                position <= '0;
            else if (st.step)
                position <= st.up ? position + POS_W'(1) : position - POS_W'(1);

            if (st.step)
                dir <= st.up;

            if (clr)
                mark_flag <= 1'b0;
            else if (idx_evt)
                mark_flag <= 1'b1;

            if (clr)
                phase_err <= 1'b0;
            else if (st.err)
                phase_err <= 1'b1;
        end
    end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qdec_pkg::*;
#(
    parameter int POS_W    = 32,
    parameter int HOLD_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qa,
    input  logic             qb,
    input  logic             qi,
    input  logic [1:0]       rst_mode,
    input  logic             mark_clr,
    output logic [POS_W-1:0] position,
    output logic             dir,
    output logic             mark_flag,
    output logic             phase_err
);
    qstep_t    st;
    logic      idx_evt;
    rst_mode_e mode_e;

    assign mode_e = rst_mode_e'(rst_mode);

    qdec_phase u_phase (
        .clk (clk),
        .rst (rst),
        .qa  (qa),
        .qb  (qb),
        .st  (st)
    );

    qdec_index #(.HOLD_CYC(HOLD_CYC)) u_index (
        .clk     (clk),
        .rst     (rst),
        .qi      (qi),
        .step    (st.step),
        .idx_evt (idx_evt)
    );

    qdec_pos #(.POS_W(POS_W)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .idx_evt   (idx_evt),
        .mode      (mode_e),
        .clr       (mark_clr),
        .position  (position),
        .dir       (dir),
        .mark_flag (mark_flag),
        .phase_err (phase_err)
    );
endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
    parameter int POS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             qa,
    input logic             qb,
    input logic [1:0]       rst_mode,
    input logic             mark_clr,
    input logic             idx_evt,
    input logic [POS_W-1:0] position,
    input logic             mark_flag,
    input logic             phase_err
);
    // R1 R2 R4 R5
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (position != $past(position)) |->
            (position == $past(position) + POS_W'(1) ||
             position == $past(position) - POS_W'(1) ||
             position == '0));

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        mark_clr |=> (!mark_flag && !phase_err));

    // R8
    mark_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mark_flag) |-> $past(idx_evt));

    // R7
    free_run_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst_mode[0]) && position == '0 && $past(position) != '0) |->
            ($past(position) == POS_W'(1) || $past(position) == '1));

    // R3
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (qa != $past(qa) && qb != $past(qb) && !mark_clr) |=> phase_err);
endmodule

bind quad_pos_counter quad_pos_counter_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .qa        (qa),
    .qb        (qb),
    .rst_mode  (rst_mode),
    .mark_clr  (mark_clr),
    .idx_evt   (idx_evt),
    .position  (position),
    .mark_flag (mark_flag),
    .phase_err (phase_err)
);

// File: tb/quad_pos_counter_test.sv
module quad_pos_counter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        qa = 1'b0, qb = 1'b0, qi = 1'b0;
    logic [1:0]  rst_mode = 2'b01;
    logic        mark_clr = 1'b0;
    logic [31:0] position;
    logic        dir, mark_flag, phase_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    quad_pos_counter uut (
        .clk(clk), .rst(rst), .qa(qa), .qb(qb), .qi(qi),
        .rst_mode(rst_mode), .mark_clr(mark_clr),
        .position(position), .dir(dir),
        .mark_flag(mark_flag), .phase_err(phase_err)
    );

    // {qa, qb, expected position, expected dir, expected phase_err}
    localparam logic [35:0] VEC [12] = '{
        {1'b1, 1'b0, 32'd1,          1'b1, 1'b0},  // R1
        {1'b1, 1'b1, 32'd2,          1'b1, 1'b0},  // R1
        {1'b0, 1'b1, 32'd3,          1'b1, 1'b0},  // R1
        {1'b0, 1'b0, 32'd4,          1'b1, 1'b0},  // R1
        {1'b0, 1'b1, 32'd3,          1'b0, 1'b0},  // R2
        {1'b1, 1'b1, 32'd2,          1'b0, 1'b0},  // R2
        {1'b1, 1'b0, 32'd1,          1'b0, 1'b0},  // R2
        {1'b0, 1'b0, 32'd0,          1'b0, 1'b0},  // R2
        {1'b1, 1'b0, 32'd1,          1'b1, 1'b0},  // R1
        {1'b0, 1'b0, 32'd0,          1'b0, 1'b0},  // R2
        {1'b0, 1'b1, 32'hFFFF_FFFF,  1'b0, 1'b0},  // R4 underflow
        {1'b0, 1'b0, 32'd0,          1'b1, 1'b0}   // R4 overflow
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive_ab(input logic a, input logic b);
        qa = a;
        qb = b;
        tick(1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(2);
        rst = 1'b0;
        tick(1);
        // R11 reset state
        chk("R11 position", position, 32'd0);
        chk("R11 dir", {31'd0, dir}, 32'd1);
        chk("R11 mark", {31'd0, mark_flag}, 32'd0);
        chk("R11 err", {31'd0, phase_err}, 32'd0);

        // R1 R2 R4 table walk in free-run mode
        for (int i = 0; i < 12; i++) begin
            drive_ab(VEC[i][35], VEC[i][34]);
            chk("R1/R2/R4 position", position, VEC[i][33:2]);
            chk("R1/R2 dir", {31'd0, dir}, {31'd0, VEC[i][1]});
            chk("R3 err", {31'd0, phase_err}, {31'd0, VEC[i][0]});
        end

        // R7 free-run ignores index; R8 marker still set
        drive_ab(1'b1, 1'b0);
        qi = 1'b1; tick(6);
        chk("R7 position", position, 32'd1);
        chk("R8 mark", {31'd0, mark_flag}, 32'd1);
        qi = 1'b0; tick(1);

        // R5 every index event zeroes
        rst_mode = 2'b00;
        drive_ab(1'b1, 1'b1);
        chk("R5 pre", position, 32'd2);
        qi = 1'b1; tick(6);
        chk("R5 first event", position, 32'd0);
        qi = 1'b0; tick(1);
        drive_ab(1'b0, 1'b1);
        qi = 1'b1; tick(6);
        chk("R5 second event", position, 32'd0);
        qi = 1'b0; tick(1);

        // R9 clear
        mark_clr = 1'b1; tick(1); mark_clr = 1'b0;
        chk("R9 mark cleared", {31'd0, mark_flag}, 32'd0);

        // R6 first-only mode
        rst_mode = 2'b10;
        drive_ab(1'b0, 1'b0);
        drive_ab(1'b1, 1'b0);
        chk("R6 pre", position, 32'd2);
        qi = 1'b1; tick(6);
        chk("R6 first zeroes", position, 32'd0);
        chk("R8 mark again", {31'd0, mark_flag}, 32'd1);
        qi = 1'b0; tick(1);
        drive_ab(1'b1, 1'b1);
        qi = 1'b1; tick(6);
        chk("R6 later ignored", position, 32'd1);
        qi = 1'b0; tick(1);

        // R10 index one clock before a count
        rst_mode = 2'b00;
        qi = 1'b1; tick(1);
        chk("R10 before: pending only", position, 32'd1);
        drive_ab(1'b0, 1'b1);
        chk("R10 before: zero on count edge", position, 32'd0);
        qi = 1'b0; tick(1);

        // R10 index two clocks after a count, then timeout
        drive_ab(1'b0, 1'b0);
        chk("R10 after: count", position, 32'd1);
        tick(1);
        qi = 1'b1; tick(1);
        chk("R10 after: latched", position, 32'd1);
        tick(2);
        chk("R10 after: still waiting", position, 32'd1);
        tick(1);
        chk("R10 after: timeout zero", position, 32'd0);
        qi = 1'b0; tick(1);

        // R10 index in same clock as a count
        qa = 1'b1; qi = 1'b1; tick(1);
        chk("R10 same: count kept", position, 32'd1);
        drive_ab(1'b1, 1'b1);
        chk("R10 same: zero on next count", position, 32'd0);
        qi = 1'b0; tick(1);

        // R9 clear beats simultaneous set
        drive_ab(1'b0, 1'b1);
        chk("R9 pre", position, 32'd1);
        mark_clr = 1'b1; qi = 1'b1; tick(6);
        chk("R9 priority mark", {31'd0, mark_flag}, 32'd0);
        chk("R5 zero under clear", position, 32'd0);
        mark_clr = 1'b0; qi = 1'b0; tick(1);

        // R3 illegal double change
        drive_ab(1'b0, 1'b0);
        chk("R3 pre", position, 32'd1);
        drive_ab(1'b1, 1'b1);
        chk("R3 no count", position, 32'd1);
        chk("R3 err set", {31'd0, phase_err}, 32'd1);
        tick(2);
        chk("R3 err sticky", {31'd0, phase_err}, 32'd1);
        mark_clr = 1'b1; tick(1); mark_clr = 1'b0;
        chk("R9 err cleared", {31'd0, phase_err}, 32'd0);

        // R11 reset with phases high: baseline, no count
        rst = 1'b1; tick(2);
        chk("R11 reset pos", position, 32'd0);
        chk("R11 reset dir", {31'd0, dir}, 32'd1);
        rst = 1'b0; tick(1);
        chk("R11 baseline", position, 32'd0);
        drive_ab(1'b0, 1'b1);
        chk("R11 first step", position, 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule